// File: doc/BRIEF.md
# Video Encoder Power-Up Sequencer

This controller sits on the host side of a video encoder and brings the device up and down in a safe order. On a power-up request it releases the device's active-low power-down pin, but only once the supplies are reported stable. It then holds for a millisecond-scale settling window and waits for the input clock to be reported stable. After that it steps through the timed bring-up: a mode-setting write strobe, release of the internal filter initialization, PLL enable, and finally DAC enable once a second millisecond window has passed.

Filter initialization is released either through an active-low pin or through two soft-reset register bits (HD and SD). A parameter picks the method. Millisecond delays come from a prescaled counter whose ticks per millisecond is a parameter, and each wait exceeds its limit by at least one tick. A power-down request at any point drops the DACs and PLL, asserts the power-down pin, and only on the following cycle reports that the supplies may be removed. Loss of supplies, or loss of the clock once the timed sequence has begun, sends the controller straight back to its safe off state. Register writes appear only as strobes with values. The serial bus that carries them is outside this block.

Top module: `vidPwrSeq`

## Requirements
- R1: Out of reset every output is in the safe state: pdN=0, pllOn=0, dacOn=0, modeWr=0, ready=0, offSafe=1. Filter init is held: in pin mode initN=0 with hdRstN=sdRstN=1; in register mode initN=1 with hdRstN=sdRstN=0.
- R2: pdN rises only on the clock edge after a cycle in which upReq=1 and suppliesOk=1. An upReq while suppliesOk=0 is ignored.
- R3: With clkOk already high, modeWr is high exactly 10*T+3 cycles after the first cycle with pdN=1, where T is ticks per millisecond. This is more than the 10 ms minimum.
- R4: The timed sequence does not start while clkOk=0. When clkOk is first sampled high after the settling window, modeWr is high in the following cycle.
- R5: modeWr is a single-cycle pulse that carries modeCfg on modeData (modeData=0 otherwise). Filter-init release follows in the next cycle, and pllOn rises in the cycle after that.
- R6: dacOn rises exactly 2*T+2 cycles after pllOn, which gives at least 2*T+1 cycles between filter-init release and DAC on.
- R7: In pin mode, release drives initN high while hdRstN and sdRstN stay 1 throughout. In register mode, initN stays 1 throughout and hdRstN and sdRstN rise together in the same cycle.
- R8: ready equals 1 exactly while the DACs are on, and stays on while upReq is held with no fault.
- R9: When downReq=1 in any active state, the next cycle has pdN=0, pllOn=0, dacOn=0 and offSafe=0. offSafe becomes 1 one cycle later.
- R10: Loss of suppliesOk in any active state, or loss of clkOk from the mode step onward, gives the full safe state of R1 (offSafe=1) on the next cycle.
- R11: downReq has priority over upReq. With both high in the off state, pdN stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| suppliesOk | input | 1 | Device supplies are stable |
| clkOk | input | 1 | Device input clock is stable |
| upReq | input | 1 | Level request to power the device up |
| downReq | input | 1 | Request to power the device down (priority) |
| modeCfg | input | MODE_W | HD/SD mode value to write in step 1 |
| pdN | output | 1 | Device power-down pin, active low |
| initN | output | 1 | Device filter-init pin, active low |
| hdRstN | output | 1 | HD soft-reset register bit value, 0 = reset |
| sdRstN | output | 1 | SD soft-reset register bit value, 0 = reset |
| pllOn | output | 1 | PLL enable register bit value |
| dacOn | output | 1 | DAC enable |
| modeWr | output | 1 | Single-cycle mode write strobe |
| modeData | output | MODE_W | Mode value accompanying modeWr |
| ready | output | 1 | Bring-up complete |
| offSafe | output | 1 | Supplies may be removed |

## Verification
The bench runs two copies side by side, one in pin mode with 3 ticks per millisecond and one in register mode with 5. It checks exact cycle offsets against 10*T and 2*T formulas. A counter that is one tick short of the margin, or that exits at the limit instead of past it, shows up as a mode strobe or DAC enable arriving a cycle early. A late clock-stable is applied well after the settling window; a design that ignored clkOk would write the mode at the window's end. Power-down and supply loss are injected mid-sequence. A design that reported offSafe together with the pin instead of a cycle later, or that let upReq win over downReq, would be caught at the next sample.

// File: rtl/vpsPkg.sv
package vpsPkg;
  typedef enum logic [2:0] {
    S_OFF, S_PWRWAIT, S_CLKWAIT, S_MODE, S_REL, S_PLL, S_ON, S_DOWN
  } seqState_t;

  typedef struct packed {
    logic clr;      // restart the millisecond counter
    logic selLong;  // compare against the settling window instead of the DAC window
  } timerCmd_t;
endpackage

// File: rtl/vpsTimer.sv
module vpsTimer
  import vpsPkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int PWR_WAIT_MS  = 10,
  parameter int DAC_WAIT_MS  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCmd_t cmd,
  output logic      waitDone
);
  localparam int MAXMS = (PWR_WAIT_MS > DAC_WAIT_MS) ? PWR_WAIT_MS : DAC_WAIT_MS;
  localparam int MSW   = $clog2(MAXMS + 2);
  localparam int TW    = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [MSW-1:0] MS_SAT  = MSW'(MAXMS + 1);
  localparam logic [TW-1:0]  TICK_LST = TW'(TICKS_PER_MS - 1);

  logic [TW-1:0]  tickCnt;
  logic [MSW-1:0] msCnt;
  logic [MSW-1:0] target;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      msCnt   <= '0;
    end else if (cmd.clr) begin
      tickCnt <= '0;
      msCnt   <= '0;
    end else if (tickCnt == TICK_LST) begin
      tickCnt <= '0;
      if (msCnt != MS_SAT) msCnt <= msCnt + 1'b1;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // elapsed = msCnt*T + tickCnt; done once elapsed > limit*T
  always_comb begin
    target   = cmd.selLong ? MSW'(PWR_WAIT_MS) : MSW'(DAC_WAIT_MS);
    waitDone = (msCnt > target) || ((msCnt == target) && (tickCnt != '0));
  end
endmodule

// File: rtl/vpsCtrl.sv
module vpsCtrl
  import vpsPkg::*;
#(
  parameter bit USE_REG_INIT = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      suppliesOk,
  input  logic      clkOk,
  input  logic      upReq,
  input  logic      downReq,
  input  logic      waitDone,
  output timerCmd_t cmd,
  output logic      pdN,
  output logic      initN,
  output logic      hdRstN,
  output logic      sdRstN,
  output logic      pllOn,
  output logic      dacOn,
  output logic      modeWr,
  output logic      ready,
  output logic      offSafe
);
  seqState_t state, nxt;
  logic released;
  logic clkNeeded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_OFF;
    else       state <= nxt;
  end

  assign clkNeeded = state inside {S_MODE, S_REL, S_PLL, S_ON};

  always_comb begin
    nxt = state;
    if (state == S_OFF) begin
      if (upReq && !downReq && suppliesOk) nxt = S_PWRWAIT;
    end else if (state == S_DOWN) begin
      nxt = S_OFF;
    end else if (downReq) begin
      nxt = S_DOWN;
    end else if (!suppliesOk || (clkNeeded && !clkOk)) begin
      nxt = S_OFF;
    end else begin
      unique case (state)
        S_PWRWAIT: if (waitDone) nxt = S_CLKWAIT;
        S_CLKWAIT: if (clkOk)    nxt = S_MODE;
        S_MODE:                  nxt = S_REL;
        S_REL:                   nxt = S_PLL;
        S_PLL:     if (waitDone) nxt = S_ON;
        default:                 nxt = state;
      endcase
    end
  end

  always_comb begin
    cmd.clr     = (state == S_OFF) || (state == S_REL);
    cmd.selLong = (state == S_PWRWAIT);
  end

  assign released = state inside {S_REL, S_PLL, S_ON};
  assign pdN      = !(state inside {S_OFF, S_DOWN});
  assign pllOn    = state inside {S_PLL, S_ON};
  assign dacOn    = (state == S_ON);
  assign ready    = (state == S_ON);
  assign modeWr   = (state == S_MODE);
  assign offSafe  = (state == S_OFF);

  generate
    if (USE_REG_INIT) begin : g_regInit
      assign initN  = 1'b1;
      assign hdRstN = released;
      assign sdRstN = released;
    end else begin : g_pinInit
      assign initN  = released;
      assign hdRstN = 1'b1;
      assign sdRstN = 1'b1;
    end
  endgenerate

  // R2: power-down pin released only after supplies stable and a request
  p_pd_needs_supply_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdN) |-> ($past(suppliesOk) && $past(upReq)));

  // R5: single-cycle mode strobe followed by filter-init release
  p_mode_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> (!modeWr && initN && hdRstN && sdRstN));

  // R6: DACs only with PLL running and filter released
  p_dac_needs_pll_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacOn) |-> ($past(pllOn) && initN && hdRstN && sdRstN));

  // R9: power-down request aborts on the next cycle
  p_down_aborts_r9: assert property (@(posedge clk) disable iff (!rstN)
    (downReq && pdN) |=> (!pdN && !pllOn && !dacOn && !offSafe));

  // R10: supply loss returns to the safe state
  p_supply_loss_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!suppliesOk && !downReq && pdN) |=> offSafe);
endmodule

// File: rtl/vidPwrSeq.sv
module vidPwrSeq
  import vpsPkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int PWR_WAIT_MS  = 10,
  parameter int DAC_WAIT_MS  = 2,
  parameter bit USE_REG_INIT = 1'b0,
  parameter int MODE_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              suppliesOk,
  input  logic              clkOk,
  input  logic              upReq,
  input  logic              downReq,
  input  logic [MODE_W-1:0] modeCfg,
  output logic              pdN,
  output logic              initN,
  output logic              hdRstN,
  output logic              sdRstN,
  output logic              pllOn,
  output logic              dacOn,
  output logic              modeWr,
  output logic [MODE_W-1:0] modeData,
  output logic              ready,
  output logic              offSafe
);
  timerCmd_t timerCmd;
  logic      waitDone;

  vpsTimer #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .PWR_WAIT_MS (PWR_WAIT_MS),
    .DAC_WAIT_MS (DAC_WAIT_MS)
  ) i_timer (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (timerCmd),
    .waitDone(waitDone)
  );

  vpsCtrl #(
    .USE_REG_INIT(USE_REG_INIT)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .suppliesOk(suppliesOk),
    .clkOk     (clkOk),
    .upReq     (upReq),
    .downReq   (downReq),
    .waitDone  (waitDone),
    .cmd       (timerCmd),
    .pdN       (pdN),
    .initN     (initN),
    .hdRstN    (hdRstN),
    .sdRstN    (sdRstN),
    .pllOn     (pllOn),
    .dacOn     (dacOn),
    .modeWr    (modeWr),
    .ready     (ready),
    .offSafe   (offSafe)
  );

  assign modeData = modeWr ? modeCfg : '0;
endmodule

// File: tb/test_vidPwrSeq.sv
module test_vidPwrSeq;
  localparam int TP = 3;   // pin-mode copy
  localparam int TR = 5;   // register-mode copy

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic suppliesOk = 1'b0, clkOk = 1'b0, upReq = 1'b0, downReq = 1'b0;
  logic [7:0] modeCfg = 8'hA5;

  logic pdNP, initNP, hdP, sdP, pllP, dacP, mwP, rdyP, safeP;
  logic pdNR, initNR, hdR, sdR, pllR, dacR, mwR, rdyR, safeR;
  logic [7:0] mdP, mdR;

  always #4 clk = ~clk;

  vidPwrSeq #(.TICKS_PER_MS(TP), .USE_REG_INIT(1'b0)) i_vidPwrSeq (
    .clk(clk), .rstN(rstN), .suppliesOk(suppliesOk), .clkOk(clkOk),
    .upReq(upReq), .downReq(downReq), .modeCfg(modeCfg),
    .pdN(pdNP), .initN(initNP), .hdRstN(hdP), .sdRstN(sdP), .pllOn(pllP),
    .dacOn(dacP), .modeWr(mwP), .modeData(mdP), .ready(rdyP), .offSafe(safeP));

  vidPwrSeq #(.TICKS_PER_MS(TR), .USE_REG_INIT(1'b1)) i_vidPwrSeqReg (
    .clk(clk), .rstN(rstN), .suppliesOk(suppliesOk), .clkOk(clkOk),
    .upReq(upReq), .downReq(downReq), .modeCfg(modeCfg),
    .pdN(pdNR), .initN(initNR), .hdRstN(hdR), .sdRstN(sdR), .pllOn(pllR),
    .dacOn(dacR), .modeWr(mwR), .modeData(mdR), .ready(rdyR), .offSafe(safeR));

  int nChk = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic allSafe(input string req);
    chk({req, " pin pdN/pll/dac"}, {pdNP, pllP, dacP, rdyP, mwP}, 0);
    chk({req, " reg pdN/pll/dac"}, {pdNR, pllR, dacR, rdyR, mwR}, 0);
    chk({req, " offSafe"}, {safeP, safeR}, 2'b11);
    chk({req, " pin init held"}, {initNP, hdP, sdP}, 3'b011);
    chk({req, " reg init held"}, {initNR, hdR, sdR}, 3'b100);
  endtask

  // Power-up run; clkOk goes high at sample d (0 = already high)
  task automatic runUp(input int d);
    int tPd[2], tMode[2], tRel[2], tPll[2], tDac[2], nMode[2], mdv[2];
    bit pinBitsOk = 1, regPinOk = 1, regSame = 1;
    int T[2], expMode;
    T[0] = TP; T[1] = TR;
    for (int k = 0; k < 2; k++) begin
      tPd[k] = -1; tMode[k] = -1; tRel[k] = -1; tPll[k] = -1; tDac[k] = -1;
      nMode[k] = 0; mdv[k] = 0;
    end
    @(negedge clk);
    upReq = 1'b1;
    if (d == 0) clkOk = 1'b1;
    for (int c = 1; c <= 260; c++) begin
      logic [1:0] pd, mw, rel, pl, dc;
      @(negedge clk);
      pd = {pdNR, pdNP}; mw = {mwR, mwP}; pl = {pllR, pllP}; dc = {dacR, dacP};
      rel = {hdR & sdR, initNP};
      if (!(hdP && sdP)) pinBitsOk = 0;
      if (!initNR) regPinOk = 0;
      if (hdR != sdR) regSame = 0;
      for (int k = 0; k < 2; k++) begin
        if (tPd[k] < 0 && pd[k]) tPd[k] = c;
        if (mw[k]) begin
          nMode[k]++;
          if (tMode[k] < 0) begin
            tMode[k] = c;
            mdv[k] = (k == 0) ? int'(mdP) : int'(mdR);
          end
        end
        if (tRel[k] < 0 && rel[k]) tRel[k] = c;
        if (tPll[k] < 0 && pl[k]) tPll[k] = c;
        if (tDac[k] < 0 && dc[k]) tDac[k] = c;
      end
      if (c == d) clkOk = 1'b1;
    end
    for (int k = 0; k < 2; k++) begin
      expMode = 10 * T[k] + 4;
      if (d != 0 && d + 1 > expMode) expMode = d + 1;
      chk("R2 pdN rises one edge after request", tPd[k], 1);
      if (d == 0) chk("R3 settle window to mode write", tMode[k] - tPd[k], 10 * T[k] + 3);
      else        chk("R4 mode write waits for clkOk", tMode[k], expMode);
      chk("R3 pdN held > 10ms before PLL", int'(tPll[k] - tPd[k] > 10 * T[k]), 1);
      chk("R5 single mode strobe", nMode[k], 1);
      chk("R5 mode data value", mdv[k], 8'hA5);
      chk("R5 release after mode", tRel[k], tMode[k] + 1);
      chk("R5 PLL after release", tPll[k], tMode[k] + 2);
      chk("R6 DAC after PLL", tDac[k], tPll[k] + 2 * T[k] + 2);
      chk("R6 release to DAC > 2ms", int'(tDac[k] - tRel[k] > 2 * T[k]), 1);
    end
    chk("R7 pin mode reset bits stay 1", pinBitsOk, 1);
    chk("R7 reg mode pin stays 1", regPinOk, 1);
    chk("R7 reg mode bits together", regSame, 1);
    chk("R8 ready with DACs", {rdyP, dacP, rdyR, dacR}, 4'hF);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    allSafe("R1 reset");
    rstN = 1'b1;

    // R2: request without supplies ignored
    upReq = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 no release without supplies", {pdNP, pdNR}, 0);
    upReq = 1'b0;
    suppliesOk = 1'b1;
    @(negedge clk);

    runUp(0);

    // R9: orderly power-down
    upReq = 1'b0; downReq = 1'b1;
    @(negedge clk);
    chk("R9 down outputs off", {pdNP, pllP, dacP, pdNR, pllR, dacR}, 0);
    chk("R9 offSafe after pin", {safeP, safeR}, 0);
    @(negedge clk);
    chk("R9 offSafe next cycle", {safeP, safeR}, 2'b11);
    downReq = 1'b0;
    clkOk = 1'b0;
    @(negedge clk);

    runUp(200);

    // R10: clock loss while on
    clkOk = 1'b0; upReq = 1'b0;
    @(negedge clk);
    allSafe("R10 clock loss");

    // R10: supply loss during settling window
    clkOk = 1'b1; upReq = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 in settling window", {pdNP, pdNR}, 2'b11);
    suppliesOk = 1'b0; upReq = 1'b0;
    @(negedge clk);
    allSafe("R10 supply loss");

    // R11: down wins over up
    suppliesOk = 1'b1; upReq = 1'b1; downReq = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 down priority", {pdNP, pdNR}, 0);
    downReq = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 sequence running", {pdNP, pdNR}, 2'b11);
    upReq = 1'b0; downReq = 1'b1;
    @(negedge clk);
    chk("R9 mid-sequence abort", {pdNP, pdNR, safeP, safeR}, 0);
    @(negedge clk);
    chk("R9 mid-sequence offSafe", {safeP, safeR}, 2'b11);
    downReq = 1'b0;
    @(negedge clk);
    allSafe("R1 idle after abort");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end
endmodule